// File: doc/BRIEF.md
# Oversize Frame Guard

This block watches one direction of a byte-wide frame stream and decides, for each frame, whether the frame is longer than the largest length it is allowed to have. A byte takes part only on a cycle where `byte_valid` is high. The byte that has `byte_last` high closes the frame. One cycle after that closing byte, the block raises `verdict_valid` for a single cycle. At the same time `oversize` gives the result. `oversize` then keeps that value until the first byte of the next frame arrives.

The length limit comes from a chain of priorities. When jumbo operation is on, no limit applies. When it is off and the programmed limit is enabled, the 15-bit programmed length is the limit. Otherwise the limit is the standard untagged maximum of 1518 bytes, which grows by the 4-byte tag allowance (to 1522) when tagged frames are enabled. The settings are sampled on the first byte of each frame and are held for the rest of that frame.

The control is a three-state machine:
- ST_IDLE: no frame is open and no verdict is being shown.
- ST_BODY: a frame is open.
- ST_DONE: the verdict cycle.

The transitions are:
- OPEN: a valid byte without last moves ST_IDLE or ST_DONE to ST_BODY.
- SHORT: a valid byte with last moves ST_IDLE or ST_DONE to ST_DONE.
- CLOSE: a valid byte with last moves ST_BODY to ST_DONE.
- REST: no valid byte moves ST_DONE to ST_IDLE.
- WAIT: ST_IDLE and ST_BODY stay where they are when no transition above applies.

Top module: `frame_len_guard`

## Requirements
- R1: When `jumbo_en` is high at the first byte of a frame, that frame is never flagged, whatever the other settings and the length.
- R2: With jumbo off and `limit_en` low and `vlan_en` low, frames of up to 1518 bytes are good and longer frames are flagged.
- R3: With jumbo off and `limit_en` low and `vlan_en` high, the limit is 1522 bytes.
- R4: With jumbo off and `limit_en` high, the limit is `limit_len`, whatever the value of `vlan_en`.
- R5: A frame whose length equals the limit is good. A frame one byte longer is flagged.
- R6: `verdict_valid` is high exactly in the cycle after a valid byte with `byte_last` high, and low at all other times.
- R7: `oversize` keeps the verdict until the first valid byte of the next frame. It reads 0 in the cycle after that byte, unless that byte also closes the frame.
- R8: The byte count saturates at 2^CNT_W-1 (65535 by default), so a frame longer than that is still flagged against any 15-bit limit.
- R9: Setting changes after the first byte of a frame do not affect that frame's verdict.
- R10: Only cycles with `byte_valid` high are counted. `byte_last` is ignored when `byte_valid` is low.
- R11: After reset, `verdict_valid` and `oversize` are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_valid | input | 1 | A byte of the frame is present this cycle |
| byte_last | input | 1 | The present byte closes the frame |
| jumbo_en | input | 1 | Removes the length limit |
| vlan_en | input | 1 | Adds the 4-byte tag allowance to the standard limit |
| limit_en | input | 1 | Selects the programmed limit instead of the standard one |
| limit_len | input | 15 | Programmed maximum length in bytes |
| verdict_valid | output | 1 | One-cycle pulse: `oversize` holds a new result |
| oversize | output | 1 | 1 = last closed frame exceeded its limit |

## Verification
The bench sends frames of exactly the limit and of one byte more under each of these settings: standard, tagged, programmed with tags on, and a programmed limit of zero. These frames separate a wrong priority order from an off-by-one compare. Jumbo frames are sent with a small programmed limit also enabled, which shows that jumbo really overrides that limit. Randomised frames insert idle bubbles that carry a stray last marker and change the settings after the first byte. These frames tell a counter that samples on valid alone apart from one that restarts or reloads its configuration mid-frame. A 70000-byte frame checked against the largest programmable limit separates a saturating counter from a wrapping one.

// File: rtl/flg_pkg.sv
package flg_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BODY = 2'd1,
        ST_DONE = 2'd2
    } flg_state_e;
endpackage

// File: rtl/flg_limit_sel.sv
// Chooses the length limit in priority order: jumbo, then programmed, then standard.
module flg_limit_sel #(
    parameter int LEN_W     = 15,
    parameter int STD_MAX   = 1518,
    parameter int TAG_BYTES = 4,
    parameter int OUT_W     = LEN_W + 1
) (
    input  logic             jumbo_en,
    input  logic             vlan_en,
    input  logic             limit_en,
    input  logic [LEN_W-1:0] limit_len,
    output logic             unlimited,
    output logic [OUT_W-1:0] limit_bytes
);
    localparam logic [OUT_W-1:0] LIM_PLAIN  = OUT_W'(STD_MAX);
    localparam logic [OUT_W-1:0] LIM_TAGGED = OUT_W'(STD_MAX + TAG_BYTES);

    always_comb begin
        unlimited   = jumbo_en;
        limit_bytes = LIM_PLAIN;
        if (!jumbo_en) begin
            if (limit_en)
                limit_bytes = OUT_W'(limit_len);
            else if (vlan_en)
                limit_bytes = LIM_TAGGED;
        end
    end
endmodule

// File: rtl/flg_len_counter.sv
// Saturating per-frame byte counter. cnt_nx is the count including this cycle's byte.
module flg_len_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             step,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cnt_nx
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    always_comb begin
        cnt_nx = cnt_q;
        if (start)
            cnt_nx = CNT_ONE;
        else if (step && (cnt_q != CNT_MAX))
            cnt_nx = cnt_q + CNT_ONE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_nx;
    end
endmodule

// File: rtl/frame_len_guard.sv
module frame_len_guard
    import flg_pkg::*;
#(
    parameter int LEN_W     = 15,
    parameter int CNT_W     = 16,
    parameter int STD_MAX   = 1518,
    parameter int TAG_BYTES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             byte_valid,
    input  logic             byte_last,
    input  logic             jumbo_en,
    input  logic             vlan_en,
    input  logic             limit_en,
    input  logic [LEN_W-1:0] limit_len,
    output logic             verdict_valid,
    output logic             oversize
);
    localparam int LIM_W = LEN_W + 1;

    flg_state_e       state_q, state_nx;
    logic             frame_start, frame_end, step;
    logic             sel_unl, unl_q, unl_eff;
    logic [LIM_W-1:0] sel_lim, lim_q, lim_eff;
    logic [CNT_W-1:0] cnt_q, cnt_nx;
    logic             over_now, oversize_q;

    assign frame_start = byte_valid && (state_q != ST_BODY);
    assign frame_end   = byte_valid && byte_last;
    assign step        = byte_valid && (state_q == ST_BODY);

    flg_limit_sel #(
        .LEN_W(LEN_W), .STD_MAX(STD_MAX), .TAG_BYTES(TAG_BYTES), .OUT_W(LIM_W)
    ) u_sel (
        .jumbo_en(jumbo_en), .vlan_en(vlan_en), .limit_en(limit_en),
        .limit_len(limit_len), .unlimited(sel_unl), .limit_bytes(sel_lim)
    );

    flg_len_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .start(frame_start), .step(step),
        .cnt_q(cnt_q), .cnt_nx(cnt_nx)
    );

    // Settings are frozen at the first byte of every frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            unl_q <= 1'b0;
            lim_q <= LIM_W'(STD_MAX);
        end else if (frame_start) begin
            unl_q <= sel_unl;
            lim_q <= sel_lim;
        end
    end

    assign unl_eff  = frame_start ? sel_unl : unl_q;
    assign lim_eff  = frame_start ? sel_lim : lim_q;
    assign over_now = !unl_eff && (cnt_nx > CNT_W'(lim_eff));

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_nx;
    end

    // Next-state logic
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE, ST_DONE: begin
                if (frame_end)
                    state_nx = ST_DONE;      // SHORT
                else if (byte_valid)
                    state_nx = ST_BODY;      // OPEN
                else
                    state_nx = ST_IDLE;      // REST / WAIT
            end
            ST_BODY: begin
                if (frame_end)
                    state_nx = ST_DONE;      // CLOSE
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // Output process
    always_ff @(posedge clk) begin
        if (!rst_n)
            oversize_q <= 1'b0;
        else if (frame_end)
            oversize_q <= over_now;
        else if (frame_start)
            oversize_q <= 1'b0;
    end

    assign verdict_valid = (state_q == ST_DONE);
    assign oversize      = oversize_q;
endmodule

// File: rtl/frame_len_guard_chk.sv
module frame_len_guard_chk
    import flg_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             byte_valid,
    input logic             byte_last,
    input logic             verdict_valid,
    input logic             oversize,
    input logic             frame_start,
    input logic             unl_q,
    input logic [CNT_W-1:0] cnt_q
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    // R6
    verdict_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && byte_last) |=> verdict_valid);

    // R6
    verdict_only_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        verdict_valid |-> $past(byte_valid && byte_last));

    // R7
    flag_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_valid |=> $stable(oversize));

    // R7
    flag_rise_at_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oversize) |-> verdict_valid);

    // R1
    jumbo_never_bad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (verdict_valid && unl_q) |-> !oversize);

    // R8
    count_saturates_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_MAX && byte_valid && !frame_start) |=> (cnt_q == CNT_MAX));
endmodule

bind frame_len_guard frame_len_guard_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_last(byte_last),
    .verdict_valid(verdict_valid), .oversize(oversize),
    .frame_start(frame_start), .unl_q(unl_q), .cnt_q(cnt_q)
);

// File: tb/frame_len_guard_bench.sv
module frame_len_guard_bench;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_MAX    = 65535;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        byte_valid = 1'b0, byte_last = 1'b0;
    logic        jumbo_en = 1'b0, vlan_en = 1'b0, limit_en = 1'b0;
    logic [14:0] limit_len = 15'd2000;
    logic        verdict_valid, oversize;

    int unsigned checks = 0, errors = 0;
    bit          done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    frame_len_guard u_frame_len_guard (
        .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_last(byte_last),
        .jumbo_en(jumbo_en), .vlan_en(vlan_en), .limit_en(limit_en),
        .limit_len(limit_len), .verdict_valid(verdict_valid), .oversize(oversize)
    );

    function automatic bit exp_bad(int len, bit j, bit v, bit e, int lim);
        int eff, cap;
        eff = (len > CNT_MAX) ? CNT_MAX : len;   // R8
        if (j) return 1'b0;                      // R1
        if (e) cap = lim;                        // R4
        else cap = v ? 1522 : 1518;              // R2 / R3
        return eff > cap;                        // R5
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Called at a negedge; returns at the negedge after the verdict hold window.
    task automatic send_frame(string req, int len, bit j, bit v, bit e, int lim,
                              int bubble_pct, bit scramble);
        bit exp;
        exp = exp_bad(len, j, v, e, lim);
        jumbo_en = j; vlan_en = v; limit_en = e; limit_len = 15'(lim);
        for (int i = 0; i < len; i++) begin
            if (bubble_pct != 0 && ($urandom % 100) < bubble_pct) begin
                byte_valid = 1'b0;
                byte_last  = $urandom % 2;       // R10: stray last ignored
                @(negedge clk);
            end
            byte_valid = 1'b1;
            byte_last  = (i == len - 1);
            @(negedge clk);
            if (i == 0) begin
                if (scramble) begin              // R9
                    jumbo_en = $urandom % 2; vlan_en = $urandom % 2;
                    limit_en = $urandom % 2; limit_len = 15'($urandom);
                end
                if (len > 1) check("R7 cleared at frame start", oversize, 0);
            end
        end
        byte_valid = 1'b0;
        byte_last  = 1'b0;
        check({"R6 verdict pulse ", req}, verdict_valid, 1);
        check({"verdict ", req}, oversize, exp);
        @(negedge clk);
        check("R6 single pulse", verdict_valid, 0);
        @(negedge clk);
        check("R7 hold", oversize, exp);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        check("R11 reset verdict_valid", verdict_valid, 0);
        check("R11 reset oversize", oversize, 0);
        rst_n = 1'b1;
        @(negedge clk);

        send_frame("R2 1518", 1518, 0, 0, 0, 2000, 0, 0);
        send_frame("R2 R5 1519", 1519, 0, 0, 0, 2000, 0, 0);
        send_frame("R3 1522", 1522, 0, 1, 0, 2000, 0, 0);
        send_frame("R3 R5 1523", 1523, 0, 1, 0, 2000, 0, 0);
        send_frame("R4 2000 tagged", 2000, 0, 1, 1, 2000, 0, 0);
        send_frame("R4 R5 2001 tagged", 2001, 0, 1, 1, 2000, 0, 0);
        send_frame("R4 below std", 101, 0, 0, 1, 100, 0, 0);
        send_frame("R4 zero limit one byte", 1, 0, 0, 1, 0, 0, 0);
        send_frame("R1 jumbo over prog", 50, 1, 0, 1, 10, 0, 0);
        send_frame("R1 jumbo long", 9000, 1, 1, 0, 2000, 0, 0);
        send_frame("R10 bubbles 1519", 1519, 0, 0, 0, 2000, 20, 0);
        send_frame("R9 scrambled 1518", 1518, 0, 0, 0, 2000, 0, 1);
        send_frame("R8 saturation", 70000, 0, 0, 1, 32767, 0, 0);
        send_frame("R1 after bad", 3, 1, 0, 0, 0, 0, 0);

        for (int k = 0; k < 25; k++) begin
            bit j, v, e;
            int lim, base, len;
            j = ($urandom % 5) == 0;
            v = $urandom % 2;
            e = $urandom % 2;
            lim = 1 + ($urandom % 2000);
            base = e ? lim : (v ? 1522 : 1518);
            if ($urandom % 2) len = base - 1 + ($urandom % 3);
            else len = 1 + ($urandom % 2100);
            if (len < 1) len = 1;
            send_frame("R9 R10 random", len, j, v, e, lim, 10, 1);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule